// File: doc/BRIEF.md
# Speculative Load Issue Gate

This block sits between the two issue slots of a dual-issue in-order core and the load pipeline. Each cycle it can take one load from either slot. Slot 0 holds the older instruction. When the load comes from slot 1 while slot 0 issues a control-flow instruction in the same cycle, the load is marked speculative. It is not sent to memory straight away. It first spends exactly one cycle in a wait state. In that cycle the branch outcome, which was captured in a register when the load was accepted, is examined. A correct prediction releases the load towards memory. A mispredict discards it silently.

Loads whose physical address falls inside a configurable non-idempotent window are never sent early. Such a load waits in a hold state until two conditions are both true:
- no stores are in flight, meaning the store buffer is empty and the cache write buffer holds no non-idempotent entries;
- the load's own tag matches the oldest uncommitted instruction at the head of commit.

A speculative load to such an address first passes through the wait state and then enters the hold state. A flush input returns everything to idle in the cycle it is seen. Address translation, the cache and the branch unit stay outside; they appear here only as plain ports.

States: `ST_IDLE` (ready for a load), `ST_SPEC_WAIT` (one-cycle branch check), `ST_NI_HOLD` (non-idempotent hold), `ST_REQ` (memory request raised), `ST_DATA` (waiting for the response).

Transitions:
- `ST_IDLE` to `ST_SPEC_WAIT` on accept of a speculative load.
- `ST_IDLE` to `ST_NI_HOLD` on accept of a non-speculative load with a non-idempotent address.
- `ST_IDLE` to `ST_REQ` on accept of any other load.
- `ST_SPEC_WAIT` to `ST_IDLE` on a registered mispredict (kill).
- `ST_SPEC_WAIT` to `ST_NI_HOLD` when the held address is non-idempotent.
- `ST_SPEC_WAIT` to `ST_REQ` otherwise.
- `ST_NI_HOLD` to `ST_REQ` once stores have drained and the load is at the commit head.
- `ST_REQ` to `ST_DATA` on grant.
- `ST_DATA` to `ST_IDLE` on the response.
- Any state to `ST_IDLE` on flush.

Top module: `spec_load_gate`

## Requirements
- R1: A slot-0 load takes priority over a slot-1 load and is never speculative (`spec_flag_o` is 0 whenever `ld0_valid_i` is 1).
- R2: When only slot 1 offers a load, `spec_flag_o` equals `br0_valid_i` in that cycle.
- R3: In the cycle after a speculative load is accepted, `mem_req_o` is 0 and `ld_ready_o` is 0 (the one-cycle branch check).
- R4: A speculative load accepted together with `br0_mispredict_i`=1 is killed. Two cycles after acceptance `ld_ready_o` is 1, and no `mem_req_o` or `res_valid_o` is ever raised for that load.
- R5: A speculative load with a correct prediction raises `mem_req_o` two cycles after acceptance, with `mem_addr_o` equal to its address.
- R6: A non-speculative load outside the non-idempotent window raises `mem_req_o` in the cycle after acceptance.
- R7: A load whose address lies in [NI_BASE, NI_BASE+NI_SIZE) keeps `mem_req_o` at 0 while `stq_empty_i` is 0 or `wbuf_ni_clear_i` is 0.
- R8: Such a load also keeps `mem_req_o` at 0 until `commit_valid_i` is 1 and `commit_tag_i` equals its tag. Being any other committing instruction is not enough.
- R9: A speculative load with a non-idempotent address goes through the wait cycle and then the hold; it is never requested before both are passed.
- R10: While `flush_i` is 1, `mem_req_o` and `res_valid_o` are 0, and in the next cycle `ld_ready_o` is 1 with the pending load gone.
- R11: In `ST_DATA`, `res_valid_o` follows `mem_rvalid_i`, `res_data_o` carries `mem_rdata_i`, and `res_tag_o` carries the load's tag.
- R12: `ld_ready_o` is 1 only in idle. Loads offered while it is 0 are ignored, and the held address and tag stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Discard any pending load, return to idle |
| ld0_valid_i | input | 1 | Slot 0 (older) issues a load |
| ld0_addr_i | input | ADDR_W | Slot 0 load physical address |
| ld0_tag_i | input | TAG_W | Slot 0 load instruction tag |
| ld1_valid_i | input | 1 | Slot 1 (younger) issues a load |
| ld1_addr_i | input | ADDR_W | Slot 1 load physical address |
| ld1_tag_i | input | TAG_W | Slot 1 load instruction tag |
| br0_valid_i | input | 1 | Slot 0 issues a control-flow instruction |
| br0_mispredict_i | input | 1 | Branch unit outcome for that instruction, same cycle |
| spec_flag_o | output | 1 | Load offered this cycle is speculative |
| ld_ready_o | output | 1 | Gate is idle and can accept a load |
| stq_empty_i | input | 1 | Store buffer is empty |
| wbuf_ni_clear_i | input | 1 | Cache write buffer holds no non-idempotent entry |
| commit_valid_i | input | 1 | Commit head holds an instruction |
| commit_tag_i | input | TAG_W | Tag of the oldest uncommitted instruction |
| mem_req_o | output | 1 | Load request to memory |
| mem_addr_o | output | ADDR_W | Address of the held load |
| mem_gnt_i | input | 1 | Memory accepts the request |
| mem_rvalid_i | input | 1 | Memory returns data |
| mem_rdata_i | input | DATA_W | Returned data |
| res_valid_o | output | 1 | Load result valid |
| res_data_o | output | DATA_W | Load result data |
| res_tag_o | output | TAG_W | Tag of the held load |

## Verification
The main function is driven with slot-0 loads with no branch, slot-1 loads with no branch, and slot-1 loads beside a branch that resolves correctly or mispredicts. These patterns are run back to back, which separates the speculative flag from slot priority, the one-cycle release from the kill, and the latency of speculative loads from plain ones. Non-idempotent loads are tried with stores pending, with the write buffer busy, with an older instruction at the commit head, and behind a branch. Each of these must keep the request low while the other conditions are already met. Flush is applied in the wait and request states. A second load is offered while the gate is busy, which shows that busy-time offers leave the held load untouched.

// File: rtl/sl_pkg.sv
package sl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPEC_WAIT,
        ST_NI_HOLD,
        ST_REQ,
        ST_DATA
    } ld_state_e;

endpackage

// File: rtl/sl_issue_sel.sv
module sl_issue_sel #(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 3
) (
    input  logic              ld0_valid_i,
    input  logic [ADDR_W-1:0] ld0_addr_i,
    input  logic [TAG_W-1:0]  ld0_tag_i,
    input  logic              ld1_valid_i,
    input  logic [ADDR_W-1:0] ld1_addr_i,
    input  logic [TAG_W-1:0]  ld1_tag_i,
    input  logic              br0_valid_i,
    output logic              pick_valid_o,
    output logic [ADDR_W-1:0] pick_addr_o,
    output logic [TAG_W-1:0]  pick_tag_o,
    output logic              pick_spec_o
);

    // The older slot wins; a younger-slot load is speculative exactly
    // when the older slot carries a control-flow instruction.
    always_comb begin
        pick_valid_o = ld0_valid_i || ld1_valid_i;
        pick_spec_o  = 1'b0;
        if (ld0_valid_i) begin
            pick_addr_o = ld0_addr_i;
            pick_tag_o  = ld0_tag_i;
        end else begin
            pick_addr_o = ld1_addr_i;
            pick_tag_o  = ld1_tag_i;
            pick_spec_o = ld1_valid_i && br0_valid_i;
        end
    end

endmodule

// File: rtl/sl_ni_guard.sv
module sl_ni_guard #(
    parameter int                ADDR_W  = 32,
    parameter int                TAG_W   = 3,
    parameter bit                NI_EN   = 1'b1,
    parameter logic [ADDR_W-1:0] NI_BASE = 'h4000_0000,
    parameter logic [ADDR_W-1:0] NI_SIZE = 'h1000_0000
) (
    input  logic [ADDR_W-1:0] new_addr_i,
    input  logic [ADDR_W-1:0] held_addr_i,
    input  logic [TAG_W-1:0]  held_tag_i,
    input  logic              stq_empty_i,
    input  logic              wbuf_ni_clear_i,
    input  logic              commit_valid_i,
    input  logic [TAG_W-1:0]  commit_tag_i,
    output logic              new_is_ni_o,
    output logic              held_is_ni_o,
    output logic              ni_go_o
);

    localparam logic [ADDR_W:0] NI_LO = {1'b0, NI_BASE};
    localparam logic [ADDR_W:0] NI_HI = {1'b0, NI_BASE} + {1'b0, NI_SIZE};

    logic stores_busy;
    logic at_head;

    generate
        if (NI_EN) begin : g_ni_on
            assign new_is_ni_o  = ({1'b0, new_addr_i}  >= NI_LO) && ({1'b0, new_addr_i}  < NI_HI);
            assign held_is_ni_o = ({1'b0, held_addr_i} >= NI_LO) && ({1'b0, held_addr_i} < NI_HI);
        end else begin : g_ni_off
            logic unused_addr;
            assign unused_addr  = ^{new_addr_i, held_addr_i};
            assign new_is_ni_o  = 1'b0;
            assign held_is_ni_o = 1'b0;
        end
    endgenerate

    // Any older uncommitted instruction blocks the load: only the head counts.
    assign stores_busy = !stq_empty_i || !wbuf_ni_clear_i;
    assign at_head     = commit_valid_i && (commit_tag_i == held_tag_i);
    assign ni_go_o     = !held_is_ni_o || (!stores_busy && at_head);

endmodule

// File: rtl/sl_load_fsm.sv
module sl_load_fsm
    import sl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int TAG_W  = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              pick_valid_i,
    input  logic [ADDR_W-1:0] pick_addr_i,
    input  logic [TAG_W-1:0]  pick_tag_i,
    input  logic              pick_spec_i,
    input  logic              br_mispredict_i,
    input  logic              new_is_ni_i,
    input  logic              held_is_ni_i,
    input  logic              ni_go_i,
    input  logic              mem_gnt_i,
    input  logic              mem_rvalid_i,
    output logic              ready_o,
    output logic              mem_req_o,
    output logic              res_valid_o,
    output logic [ADDR_W-1:0] held_addr_o,
    output logic [TAG_W-1:0]  held_tag_o
);

    ld_state_e state_q, state_d;
    logic      accept;
    logic      mis_q;

    assign accept = (state_q == ST_IDLE) && pick_valid_i && !flush_i;

    // State register and captured load, including the branch outcome.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q     <= ST_IDLE;
            mis_q       <= 1'b0;
            held_addr_o <= '0;
            held_tag_o  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                held_addr_o <= pick_addr_i;
                held_tag_o  <= pick_tag_i;
                mis_q       <= pick_spec_i && br_mispredict_i;
            end
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (pick_spec_i)      state_d = ST_SPEC_WAIT;
                    else if (new_is_ni_i) state_d = ST_NI_HOLD;
                    else                  state_d = ST_REQ;
                end
            end
            ST_SPEC_WAIT: begin
                if (mis_q)             state_d = ST_IDLE;
                else if (held_is_ni_i) state_d = ST_NI_HOLD;
                else                   state_d = ST_REQ;
            end
            ST_NI_HOLD: if (ni_go_i)      state_d = ST_REQ;
            ST_REQ:     if (mem_gnt_i)    state_d = ST_DATA;
            ST_DATA:    if (mem_rvalid_i) state_d = ST_IDLE;
            default:                      state_d = ST_IDLE;
        endcase
        if (flush_i) state_d = ST_IDLE;
    end

    // Outputs.
    always_comb begin
        ready_o     = 1'b0;
        mem_req_o   = 1'b0;
        res_valid_o = 1'b0;
        unique case (state_q)
            ST_IDLE:      ready_o     = 1'b1;
            ST_SPEC_WAIT: ready_o     = 1'b0;
            ST_NI_HOLD:   ready_o     = 1'b0;
            ST_REQ:       mem_req_o   = !flush_i;
            ST_DATA:      res_valid_o = mem_rvalid_i && !flush_i;
            default:      ready_o     = 1'b0;
        endcase
    end

endmodule

// File: rtl/spec_load_gate.sv
module spec_load_gate #(
    parameter int                ADDR_W  = 32,
    parameter int                DATA_W  = 32,
    parameter int                TAG_W   = 3,
    parameter bit                NI_EN   = 1'b1,
    parameter logic [ADDR_W-1:0] NI_BASE = 'h4000_0000,
    parameter logic [ADDR_W-1:0] NI_SIZE = 'h1000_0000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              flush_i,
    input  logic              ld0_valid_i,
    input  logic [ADDR_W-1:0] ld0_addr_i,
    input  logic [TAG_W-1:0]  ld0_tag_i,
    input  logic              ld1_valid_i,
    input  logic [ADDR_W-1:0] ld1_addr_i,
    input  logic [TAG_W-1:0]  ld1_tag_i,
    input  logic              br0_valid_i,
    input  logic              br0_mispredict_i,
    output logic              spec_flag_o,
    output logic              ld_ready_o,
    input  logic              stq_empty_i,
    input  logic              wbuf_ni_clear_i,
    input  logic              commit_valid_i,
    input  logic [TAG_W-1:0]  commit_tag_i,
    output logic              mem_req_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    input  logic              mem_gnt_i,
    input  logic              mem_rvalid_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              res_valid_o,
    output logic [DATA_W-1:0] res_data_o,
    output logic [TAG_W-1:0]  res_tag_o
);

    logic              pick_valid;
    logic [ADDR_W-1:0] pick_addr;
    logic [TAG_W-1:0]  pick_tag;
    logic              new_is_ni;
    logic              held_is_ni;
    logic              ni_go;

    sl_issue_sel #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_sel (
        .ld0_valid_i  (ld0_valid_i),
        .ld0_addr_i   (ld0_addr_i),
        .ld0_tag_i    (ld0_tag_i),
        .ld1_valid_i  (ld1_valid_i),
        .ld1_addr_i   (ld1_addr_i),
        .ld1_tag_i    (ld1_tag_i),
        .br0_valid_i  (br0_valid_i),
        .pick_valid_o (pick_valid),
        .pick_addr_o  (pick_addr),
        .pick_tag_o   (pick_tag),
        .pick_spec_o  (spec_flag_o)
    );

    sl_ni_guard #(
        .ADDR_W(ADDR_W), .TAG_W(TAG_W), .NI_EN(NI_EN),
        .NI_BASE(NI_BASE), .NI_SIZE(NI_SIZE)
    ) u_guard (
        .new_addr_i      (pick_addr),
        .held_addr_i     (mem_addr_o),
        .held_tag_i      (res_tag_o),
        .stq_empty_i     (stq_empty_i),
        .wbuf_ni_clear_i (wbuf_ni_clear_i),
        .commit_valid_i  (commit_valid_i),
        .commit_tag_i    (commit_tag_i),
        .new_is_ni_o     (new_is_ni),
        .held_is_ni_o    (held_is_ni),
        .ni_go_o         (ni_go)
    );

    sl_load_fsm #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_fsm (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .flush_i         (flush_i),
        .pick_valid_i    (pick_valid),
        .pick_addr_i     (pick_addr),
        .pick_tag_i      (pick_tag),
        .pick_spec_i     (spec_flag_o),
        .br_mispredict_i (br0_mispredict_i),
        .new_is_ni_i     (new_is_ni),
        .held_is_ni_i    (held_is_ni),
        .ni_go_i         (ni_go),
        .mem_gnt_i       (mem_gnt_i),
        .mem_rvalid_i    (mem_rvalid_i),
        .ready_o         (ld_ready_o),
        .mem_req_o       (mem_req_o),
        .res_valid_o     (res_valid_o),
        .held_addr_o     (mem_addr_o),
        .held_tag_o      (res_tag_o)
    );

    assign res_data_o = mem_rdata_i;

endmodule

// File: rtl/sl_gate_checker.sv
module sl_gate_checker #(
    parameter int                ADDR_W  = 32,
    parameter int                TAG_W   = 3,
    parameter bit                NI_EN   = 1'b1,
    parameter logic [ADDR_W-1:0] NI_BASE = 'h4000_0000,
    parameter logic [ADDR_W-1:0] NI_SIZE = 'h1000_0000
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              flush_i,
    input logic              ld0_valid_i,
    input logic [ADDR_W-1:0] ld0_addr_i,
    input logic              ld1_valid_i,
    input logic              br0_valid_i,
    input logic              br0_mispredict_i,
    input logic              spec_flag_o,
    input logic              ld_ready_o,
    input logic              stq_empty_i,
    input logic              wbuf_ni_clear_i,
    input logic              commit_valid_i,
    input logic [TAG_W-1:0]  commit_tag_i,
    input logic              mem_req_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic              mem_rvalid_i,
    input logic              res_valid_o,
    input logic [TAG_W-1:0]  res_tag_o
);

    localparam logic [ADDR_W:0] WIN_LO = {1'b0, NI_BASE};
    localparam logic [ADDR_W:0] WIN_HI = {1'b0, NI_BASE} + {1'b0, NI_SIZE};

    logic ld0_in_win;
    logic req_in_win;
    logic spec_take;

    assign ld0_in_win = NI_EN && ({1'b0, ld0_addr_i} >= WIN_LO) && ({1'b0, ld0_addr_i} < WIN_HI);
    assign req_in_win = NI_EN && ({1'b0, mem_addr_o} >= WIN_LO) && ({1'b0, mem_addr_o} < WIN_HI);
    assign spec_take  = ld_ready_o && !flush_i && spec_flag_o;

    p_slot0_plain_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld0_valid_i |-> !spec_flag_o);

    p_flag_follows_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!ld0_valid_i && ld1_valid_i) |-> (spec_flag_o == br0_valid_i));

    p_wait_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        spec_take |=> (!mem_req_o && !ld_ready_o));

    p_kill_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (spec_take && br0_mispredict_i) |=> ##1 (ld_ready_o && !mem_req_o && !res_valid_o));

    p_plain_fast_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ld_ready_o && !flush_i && ld0_valid_i && !ld0_in_win) |=> (mem_req_o || flush_i));

    p_ni_stores_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(mem_req_o) && req_in_win) |-> $past(stq_empty_i && wbuf_ni_clear_i));

    p_ni_head_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(mem_req_o) && req_in_win) |-> $past(commit_valid_i && (commit_tag_i == res_tag_o)));

    p_flush_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |-> (!mem_req_o && !res_valid_o));

    p_flush_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        flush_i |=> ld_ready_o);

    p_result_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        res_valid_o |-> mem_rvalid_i);

    p_busy_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mem_req_o || res_valid_o) |-> !ld_ready_o);

endmodule

bind spec_load_gate sl_gate_checker #(
    .ADDR_W(ADDR_W), .TAG_W(TAG_W), .NI_EN(NI_EN),
    .NI_BASE(NI_BASE), .NI_SIZE(NI_SIZE)
) u_chk (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .flush_i          (flush_i),
    .ld0_valid_i      (ld0_valid_i),
    .ld0_addr_i       (ld0_addr_i),
    .ld1_valid_i      (ld1_valid_i),
    .br0_valid_i      (br0_valid_i),
    .br0_mispredict_i (br0_mispredict_i),
    .spec_flag_o      (spec_flag_o),
    .ld_ready_o       (ld_ready_o),
    .stq_empty_i      (stq_empty_i),
    .wbuf_ni_clear_i  (wbuf_ni_clear_i),
    .commit_valid_i   (commit_valid_i),
    .commit_tag_i     (commit_tag_i),
    .mem_req_o        (mem_req_o),
    .mem_addr_o       (mem_addr_o),
    .mem_rvalid_i     (mem_rvalid_i),
    .res_valid_o      (res_valid_o),
    .res_tag_o        (res_tag_o)
);

// File: tb/spec_load_gate_test.sv
module spec_load_gate_test;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int TW = 3;
    localparam logic [AW-1:0] WIN_ADDR = 32'h4000_0040;

    // Vector fields: {slot1, branch, mispredict, exp_spec, exp_kill, exp_latency[1:0]}
    localparam int NVEC = 8;
    localparam logic [6:0] VECS [NVEC] = '{
        7'b0_0_0_0_0_01,   // slot 0, no branch
        7'b1_1_0_1_0_10,   // slot 1 + branch, correct
        7'b1_1_1_1_1_10,   // slot 1 + branch, mispredict
        7'b1_0_0_0_0_01,   // slot 1, no branch
        7'b1_1_0_1_0_10,   // back-to-back pair
        7'b1_1_1_1_1_10,
        7'b1_1_0_1_0_10,
        7'b0_0_0_0_0_01
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          ld0_v = 1'b0, ld1_v = 1'b0;
    logic [AW-1:0] ld0_a = '0, ld1_a = '0;
    logic [TW-1:0] ld0_t = '0, ld1_t = '0;
    logic          br_v = 1'b0, br_mis = 1'b0;
    logic          spec_flag, ready;
    logic          stq_empty = 1'b1, wbuf_clear = 1'b1;
    logic          cm_v = 1'b0;
    logic [TW-1:0] cm_t = '0;
    logic          req;
    logic [AW-1:0] addr;
    logic          gnt = 1'b1, rvalid = 1'b0;
    logic [DW-1:0] rdata = '0;
    logic          rsp_v;
    logic [DW-1:0] rsp_d;
    logic [TW-1:0] rsp_t;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spec_load_gate uut (
        .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
        .ld0_valid_i(ld0_v), .ld0_addr_i(ld0_a), .ld0_tag_i(ld0_t),
        .ld1_valid_i(ld1_v), .ld1_addr_i(ld1_a), .ld1_tag_i(ld1_t),
        .br0_valid_i(br_v), .br0_mispredict_i(br_mis),
        .spec_flag_o(spec_flag), .ld_ready_o(ready),
        .stq_empty_i(stq_empty), .wbuf_ni_clear_i(wbuf_clear),
        .commit_valid_i(cm_v), .commit_tag_i(cm_t),
        .mem_req_o(req), .mem_addr_o(addr), .mem_gnt_i(gnt),
        .mem_rvalid_i(rvalid), .mem_rdata_i(rdata),
        .res_valid_o(rsp_v), .res_data_o(rsp_d), .res_tag_o(rsp_t)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic offer(input logic slot1, input logic br, input logic mis,
                         input logic [AW-1:0] a, input logic [TW-1:0] t);
        ld0_v = !slot1; ld0_a = a; ld0_t = t;
        ld1_v = slot1;  ld1_a = a; ld1_t = t;
        br_v = br; br_mis = mis;
    endtask

    task automatic clear_offer();
        ld0_v = 1'b0; ld1_v = 1'b0; br_v = 1'b0; br_mis = 1'b0;
    endtask

    // Drives one load at a negedge and follows it to the end.
    task automatic run_load(input logic [6:0] v, input logic [AW-1:0] a, input logic [TW-1:0] t);
        @(negedge clk);
        offer(v[6], v[5], v[4], a, t);
        #1;
        chk("R2/R1 speculative flag", spec_flag, v[3]);
        chk("R12 ready before accept", ready, 1);
        step();
        clear_offer();
        if (v[1:0] == 2'd2) begin
            chk("R3 no request in wait cycle", req, 0);
            chk("R3 not ready in wait cycle", ready, 0);
            step();
            if (v[2]) begin
                chk("R4 killed load back to idle", ready, 1);
                chk("R4 killed load no request", req, 0);
                chk("R4 killed load no result", rsp_v, 0);
                return;
            end
            chk("R5 released after one-cycle check", req, 1);
        end else begin
            chk("R6 plain load requests next cycle", req, 1);
        end
        chk("R5/R6 request address", addr, a);
        @(negedge clk);
        rvalid = 1'b1; rdata = ~a;
        #1;
        chk("R11 result valid", rsp_v, 1);
        chk("R11 result data", rsp_d, ~a);
        chk("R11 result tag", rsp_t, t);
        @(negedge clk);
        rvalid = 1'b0;
        #1;
        chk("R12 ready after result", ready, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        // Reset state
        #(CLK_PERIOD * 2 + 2);
        chk("R12 reset ready", ready, 1);
        chk("R10 reset no request", req, 0);
        chk("R11 reset no result", rsp_v, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table-driven pairs, back to back
        for (int i = 0; i < NVEC; i++) begin
            run_load(VECS[i], 32'h1000 + 32'(i * 4), TW'(i));
        end

        // R1: both slots valid, older slot wins
        @(negedge clk);
        ld0_v = 1'b1; ld0_a = 32'h2000; ld0_t = 3'd1;
        ld1_v = 1'b1; ld1_a = 32'h3000; ld1_t = 3'd2;
        #1;
        chk("R1 slot 0 priority not speculative", spec_flag, 0);
        step();
        clear_offer();
        chk("R1 slot 0 address chosen", addr, 32'h2000);
        chk("R6 slot 0 requested next cycle", req, 1);
        @(negedge clk); rvalid = 1'b1; #1;
        chk("R1 slot 0 tag returned", rsp_t, 3'd1);
        @(negedge clk); rvalid = 1'b0;

        // R7 / R8: non-idempotent load with pending stores
        stq_empty = 1'b0; wbuf_clear = 1'b1; cm_v = 1'b1; cm_t = 3'd5;
        @(negedge clk);
        offer(1'b0, 1'b0, 1'b0, WIN_ADDR, 3'd5);
        step();
        clear_offer();
        for (int k = 0; k < 3; k++) begin
            chk("R7 held while store buffer busy", req, 0);
            step();
        end
        stq_empty = 1'b1; wbuf_clear = 1'b0;
        step();
        chk("R7 held while write buffer has entries", req, 0);
        step();
        chk("R7 held while write buffer has entries", req, 0);
        wbuf_clear = 1'b1; cm_t = 3'd4;
        step();
        chk("R8 held behind older instruction", req, 0);
        cm_v = 1'b0; cm_t = 3'd5;
        step();
        chk("R8 held when commit head empty", req, 0);
        cm_v = 1'b1;
        step();
        chk("R8 released at commit head", req, 1);
        chk("R8 address", addr, WIN_ADDR);
        @(negedge clk); rvalid = 1'b1; #1;
        chk("R11 non-idempotent result", rsp_v, 1);
        @(negedge clk); rvalid = 1'b0;

        // R9: speculative non-idempotent load, everything else clear
        cm_t = 3'd6;
        @(negedge clk);
        offer(1'b1, 1'b1, 1'b0, WIN_ADDR + 32'h8, 3'd6);
        step();
        clear_offer();
        chk("R9 wait cycle first", req, 0);
        step();
        chk("R9 hold cycle second", req, 0);
        step();
        chk("R9 request after wait and hold", req, 1);
        @(negedge clk); rvalid = 1'b1;
        @(negedge clk); rvalid = 1'b0;
        cm_v = 1'b0;

        // R10: flush in the wait state
        @(negedge clk);
        offer(1'b1, 1'b1, 1'b0, 32'h5000, 3'd2);
        step();
        clear_offer();
        flush = 1'b1;
        #1;
        chk("R10 no request during flush", req, 0);
        step();
        flush = 1'b0;
        chk("R10 idle after flush", ready, 1);
        step();
        chk("R10 flushed load never requested", req, 0);

        // R10: flush while requesting
        gnt = 1'b0;
        @(negedge clk);
        offer(1'b0, 1'b0, 1'b0, 32'h5100, 3'd3);
        step();
        clear_offer();
        chk("R6 request raised", req, 1);
        flush = 1'b1;
        #1;
        chk("R10 request dropped by flush", req, 0);
        step();
        flush = 1'b0;
        chk("R10 ready after flush in request", ready, 1);

        // R12: offers while busy are ignored
        @(negedge clk);
        offer(1'b0, 1'b0, 1'b0, 32'h6000, 3'd1);
        step();
        offer(1'b0, 1'b0, 1'b0, 32'h7000, 3'd7);
        #1;
        chk("R12 not ready while busy", ready, 0);
        step();
        clear_offer();
        chk("R12 held address unchanged", addr, 32'h6000);
        chk("R12 held tag unchanged", rsp_t, 3'd1);
        gnt = 1'b1;
        step();
        rvalid = 1'b1; #1;
        chk("R12 result belongs to first load", rsp_t, 3'd1);
        @(negedge clk); rvalid = 1'b0;
        step();
        chk("R12 ignored load never requested", req, 0);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule